// File: doc/BRIEF.md
# PS/2 Host Receive Frame Engine

This block assembles device-to-host frames on a PS/2 link. Each frame is eleven bits long: a start bit that must be 0, eight data bits with the least significant bit first, an odd parity bit, and a stop bit that must be 1. An interval checker sits upstream of the block. It qualifies each falling clock edge. The engine samples the already synchronised data line only in cycles where that checker raises its accept strobe. The device changes data only on the rising clock edge, so a sample taken at an accepted falling edge lands inside the low phase, where the line is stable.

The byte is delivered as soon as the parity bit agrees with it. The engine does not wait for the stop bit. Several conditions are errors: a bad start bit, a bad parity bit, a bad stop bit, a bit position outside the frame, or a timeout strobe that arrives while a frame is in progress. On any error the engine clears its bit counter and its byte buffer. If host writes are enabled, it also asks the transmitter to send the resend command. If host writes are disabled, the frame is simply dropped.

Top module: `ps2_rx_frame`

## Requirements
- R1: After reset, rx_valid and resend_req are 0, rx_byte is 0x00, and the engine waits for a start bit.
- R2: A frame is a start bit of 0, eight data bits sent least significant bit first, an odd parity bit (the nine bits together hold an odd number of ones), and a stop bit of 1. A well-formed frame delivers its eight data bits on rx_byte.
- R3: rx_valid is high for exactly one cycle. That cycle is the one after the clock edge that samples an accepted parity bit, which is before the stop bit arrives.
- R4: A start bit sampled as 1 is an error. The engine stays waiting for a start bit.
- R5: A parity bit that gives an even count of ones is an error. No byte is delivered.
- R6: A stop bit sampled as 0 is an error. The byte has already been delivered at parity time, and a resend request follows it.
- R7: A timeout strobe while a frame is in progress is an error and returns the engine to waiting for a start bit. A timeout strobe while the engine is waiting for a start bit is ignored.
- R8: When a timeout strobe and an accept strobe arrive in the same cycle in the middle of a frame, the timeout wins and the data bit is discarded.
- R9: With wr_en high, every error raises resend_req for one cycle, in the cycle after the offending strobe. During that cycle resend_cmd is 0xFE. resend_req and rx_valid are never high together.
- R10: With wr_en low, an error raises no resend_req and the frame is dropped.
- R11: The data line is ignored in every cycle in which edge_ok is low.
- R12: After any error, the next well-formed frame is received correctly from its start bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_data | input | 1 | Synchronised PS/2 data line |
| edge_ok | input | 1 | Strobe marking an accepted falling clock edge |
| edge_timeout | input | 1 | Strobe from the interval checker marking an over-long edge interval |
| wr_en | input | 1 | Configuration bit that enables host writes, and with them resend requests |
| rx_byte | output | 8 | Last received data byte |
| rx_valid | output | 1 | One-cycle pulse marking a new rx_byte |
| resend_req | output | 1 | One-cycle request to transmit resend_cmd |
| resend_cmd | output | 8 | Command byte to transmit on a resend request (0xFE) |

## Verification
Two events can land in the same cycle: an accepted edge that would sample a data bit, and a timeout strobe raised mid-frame. The bench provokes this by asserting both strobes together after two data bits. It expects exactly one resend request and no byte. It then sends a clean frame, which must decode correctly, and this shows that the colliding bit was thrown away rather than shifted in. The bench also covers a bad stop bit after a good parity bit. In that case a byte delivery and a resend fall on successive accepted edges, and the scoreboard must see them in that order and never in the same cycle.

// File: rtl/ps2rx_pkg.sv
package ps2rx_pkg;

   typedef enum logic [2:0] {
      PH_START  = 3'd0,
      PH_DATA   = 3'd1,
      PH_PARITY = 3'd2,
      PH_STOP   = 3'd3,
      PH_BAD    = 3'd4
   } ps2rx_phase_e;

endpackage

// File: rtl/ps2rx_bit_ctr.sv
module ps2rx_bit_ctr
   import ps2rx_pkg::*;
#(
   parameter int DATA_BITS = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         step,
   input  logic         clear,
   output ps2rx_phase_e phase
);
   localparam int LAST = DATA_BITS + 2;
   localparam int CW   = $clog2(LAST + 1);

   logic [CW-1:0] cnt;

   always_comb begin
      if (cnt == '0)
         phase = PH_START;
      else if (cnt <= CW'(DATA_BITS))
         phase = PH_DATA;
      else if (cnt == CW'(DATA_BITS + 1))
         phase = PH_PARITY;
      else if (cnt == CW'(LAST))
         phase = PH_STOP;
      else
         phase = PH_BAD;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (clear)
         cnt <= '0;
      else if (step)
         cnt <= (phase == PH_STOP) ? '0 : cnt + 1'b1;
   end

   // R2: the position never leaves the eleven-bit frame
   p_cnt_in_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
      phase != PH_BAD);

endmodule

// File: rtl/ps2rx_shifter.sv
module ps2rx_shifter #(
   parameter int DATA_BITS = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 shift,
   input  logic                 bit_in,
   input  logic                 clear,
   output logic [DATA_BITS-1:0] word
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         word <= '0;
      else if (clear)
         word <= '0;
      else if (shift)
         word <= {bit_in, word[DATA_BITS-1:1]};
   end

   // R12: a clear leaves an empty buffer
   p_clear_empties_r12: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> word == '0);

endmodule

// File: rtl/ps2rx_parity.sv
module ps2rx_parity #(
   parameter int DATA_BITS = 8,
   parameter bit ODD       = 1'b1
) (
   input  logic [DATA_BITS-1:0] word,
   input  logic                 par_bit,
   output logic                 good
);
   generate
      if (ODD) begin : g_odd
         assign good = ^{word, par_bit};
      end else begin : g_even
         assign good = ~^{word, par_bit};
      end
   endgenerate
endmodule

// File: rtl/ps2_rx_frame.sv
module ps2_rx_frame
   import ps2rx_pkg::*;
#(
   parameter int         DATA_BITS   = 8,
   parameter bit         PARITY_ODD  = 1'b1,
   parameter logic [7:0] RESEND_CODE = 8'hFE
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 rx_data,
   input  logic                 edge_ok,
   input  logic                 edge_timeout,
   input  logic                 wr_en,
   output logic [DATA_BITS-1:0] rx_byte,
   output logic                 rx_valid,
   output logic                 resend_req,
   output logic [7:0]           resend_cmd
);
   initial begin
      assert (DATA_BITS >= 2 && DATA_BITS <= 16)
         else $error("ps2_rx_frame: DATA_BITS out of range");
   end

   ps2rx_phase_e         phase;
   logic [DATA_BITS-1:0] word;
   logic                 par_good;
   logic                 take, tmo_err, start_err, par_err, stop_err, sync_err;
   logic                 any_err, par_ok;

   // the timeout outranks an edge in the same cycle
   assign tmo_err   = edge_timeout && (phase != PH_START);
   assign take      = edge_ok && !edge_timeout;
   assign start_err = take && (phase == PH_START) && rx_data;
   assign par_err   = take && (phase == PH_PARITY) && !par_good;
   assign stop_err  = take && (phase == PH_STOP) && !rx_data;
   assign sync_err  = take && (phase == PH_BAD);
   assign any_err   = tmo_err || start_err || par_err || stop_err || sync_err;
   assign par_ok    = take && (phase == PH_PARITY) && par_good;

   ps2rx_bit_ctr #(.DATA_BITS(DATA_BITS)) i_ctr (
      .clk   (clk),
      .rst_n (rst_n),
      .step  (take && !any_err),
      .clear (any_err),
      .phase (phase)
   );

   ps2rx_shifter #(.DATA_BITS(DATA_BITS)) i_shift (
      .clk    (clk),
      .rst_n  (rst_n),
      .shift  (take && (phase == PH_DATA)),
      .bit_in (rx_data),
      .clear  (any_err),
      .word   (word)
   );

   ps2rx_parity #(.DATA_BITS(DATA_BITS), .ODD(PARITY_ODD)) i_par (
      .word    (word),
      .par_bit (rx_data),
      .good    (par_good)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_byte    <= '0;
         rx_valid   <= 1'b0;
         resend_req <= 1'b0;
      end else begin
         rx_valid   <= par_ok;
         resend_req <= any_err && wr_en;
         if (par_ok)
            rx_byte <= word;
      end
   end

   assign resend_cmd = RESEND_CODE;

   p_valid_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid);

   p_start_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_ok && !edge_timeout && phase == PH_START && rx_data) |=> phase == PH_START);

   p_tmo_mid_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_timeout && phase != PH_START) |=> phase == PH_START);

   p_tmo_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_timeout && phase == PH_START) |=> !resend_req);

   p_tmo_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_ok && edge_timeout && phase == PH_PARITY) |=> !rx_valid);

   p_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(rx_valid && resend_req));

   p_resend_gated_r10: assert property (@(posedge clk) disable iff (!rst_n)
      resend_req |-> $past(wr_en));

   p_quiet_line_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!edge_ok && !edge_timeout) |=> $stable(phase) && !rx_valid && !resend_req);

endmodule

// File: tb/test_ps2_rx_frame.sv
`timescale 1ns/1ps
module test_ps2_rx_frame;

   typedef struct {
      bit         is_resend;
      logic [7:0] val;
      string      req;
   } exp_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rx_data = 1'b1;
   logic       edge_ok = 1'b0;
   logic       edge_timeout = 1'b0;
   logic       wr_en = 1'b1;
   logic [7:0] rx_byte;
   logic       rx_valid;
   logic       resend_req;
   logic [7:0] resend_cmd;

   int   checks = 0;
   int   errors = 0;
   exp_t sb[$];

   always #2.5 clk = ~clk;

   ps2_rx_frame i_ps2_rx_frame (
      .clk          (clk),
      .rst_n        (rst_n),
      .rx_data      (rx_data),
      .edge_ok      (edge_ok),
      .edge_timeout (edge_timeout),
      .wr_en        (wr_en),
      .rx_byte      (rx_byte),
      .rx_valid     (rx_valid),
      .resend_req   (resend_req),
      .resend_cmd   (resend_cmd)
   );

   task automatic push(input bit rs, input logic [7:0] v, input string req);
      exp_t e;
      e.is_resend = rs;
      e.val = v;
      e.req = req;
      sb.push_back(e);
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n) begin
         if (rx_valid && resend_req) begin
            checks++; errors++;
            $display("FAIL R9: rx_valid and resend_req together, actual 1/1 expected exclusive");
         end
         if (rx_valid || resend_req) begin
            checks++;
            if (sb.size() == 0) begin
               errors++;
               $display("FAIL R10/R11: unexpected %s, actual %h expected nothing",
                        rx_valid ? "byte" : "resend", rx_valid ? rx_byte : resend_cmd);
            end else begin
               exp_t e;
               e = sb.pop_front();
               if (e.is_resend != resend_req || e.val != (resend_req ? resend_cmd : rx_byte)) begin
                  errors++;
                  $display("FAIL %s: actual %s %h expected %s %h", e.req,
                           resend_req ? "resend" : "byte", resend_req ? resend_cmd : rx_byte,
                           e.is_resend ? "resend" : "byte", e.val);
               end
            end
         end
      end
   end

   // one accepted edge with the bit, then noise on the line while edge_ok is low (R11)
   task automatic strobe(input logic b);
      @(negedge clk);
      rx_data = b;
      edge_ok = 1'b1;
      @(negedge clk);
      edge_ok = 1'b0;
      rx_data = ~b;
      @(negedge clk);
      rx_data = b;
      @(negedge clk);
   endtask

   task automatic check_empty(input string req);
      repeat (4) @(negedge clk);
      checks++;
      if (sb.size() != 0) begin
         errors++;
         $display("FAIL %s: pending events actual %0d expected 0", req, sb.size());
         sb.delete();
      end
   endtask

   // mode: 0 good, 1 bad parity (no stop sent), 2 bad stop
   task automatic send_frame(input logic [7:0] b, input int mode, input string req);
      logic par;
      par = ~^b;
      strobe(1'b0);
      for (int i = 0; i < 8; i++) strobe(b[i]);
      if (mode == 1) begin
         if (wr_en) push(1'b1, 8'hFE, req);
         strobe(~par);
         check_empty(req);
      end else begin
         push(1'b0, b, req);
         strobe(par);
         // R3: byte already out before the stop bit
         checks++;
         if (sb.size() != 0) begin
            errors++;
            $display("FAIL R3: byte not delivered before stop, actual pending %0d expected 0", sb.size());
            sb.delete();
         end
         if (mode == 2 && wr_en) push(1'b1, 8'hFE, req);
         strobe(mode == 2 ? 1'b0 : 1'b1);
         check_empty(req);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: run hung, actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      checks++;
      if (rx_valid !== 1'b0 || resend_req !== 1'b0 || rx_byte !== 8'h00) begin
         errors++;
         $display("FAIL R1: reset outputs actual %b %b %h expected 0 0 00", rx_valid, resend_req, rx_byte);
      end
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      checks++;
      if (rx_valid !== 1'b0 || resend_req !== 1'b0) begin
         errors++;
         $display("FAIL R1: idle outputs actual %b %b expected 0 0", rx_valid, resend_req);
      end

      // R2 R11 good frames
      send_frame(8'hA5, 0, "R2");
      send_frame(8'h00, 0, "R2");
      send_frame(8'hFF, 0, "R11");
      send_frame(8'h3C, 0, "R2");

      // R4 start bit high
      push(1'b1, 8'hFE, "R4");
      strobe(1'b1);
      check_empty("R4");
      send_frame(8'h5A, 0, "R12");

      // R5 bad parity
      send_frame(8'h81, 1, "R5");
      send_frame(8'h7E, 0, "R12");

      // R6 bad stop
      send_frame(8'h42, 2, "R6");
      send_frame(8'h19, 0, "R12");

      // R7 timeout mid-frame
      strobe(1'b0); strobe(1'b1); strobe(1'b0); strobe(1'b1);
      push(1'b1, 8'hFE, "R7");
      @(negedge clk); edge_timeout = 1'b1;
      @(negedge clk); edge_timeout = 1'b0;
      check_empty("R7");
      send_frame(8'hC3, 0, "R12");

      // R7 timeout while idle is ignored
      @(negedge clk); edge_timeout = 1'b1;
      @(negedge clk); edge_timeout = 1'b0;
      check_empty("R7");
      send_frame(8'h96, 0, "R7");

      // R8 timeout and edge together mid-frame
      strobe(1'b0); strobe(1'b1); strobe(1'b1);
      push(1'b1, 8'hFE, "R8");
      @(negedge clk); edge_timeout = 1'b1; edge_ok = 1'b1; rx_data = 1'b0;
      @(negedge clk); edge_timeout = 1'b0; edge_ok = 1'b0;
      check_empty("R8");
      send_frame(8'h24, 0, "R8");

      // R10 writes disabled: errors dropped silently
      wr_en = 1'b0;
      send_frame(8'hE7, 1, "R10");
      strobe(1'b1);
      check_empty("R10");
      send_frame(8'h6D, 0, "R10");
      wr_en = 1'b1;

      // R9 resend again with writes re-enabled
      push(1'b1, 8'hFE, "R9");
      strobe(1'b1);
      check_empty("R9");

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule